// File: doc/BRIEF.md
# Three-Level Page Table Walker

The walker turns a virtual address into a physical address by reading one page-table entry from memory at each of three levels. A translation request carries the virtual address. The first table is found through a base page number held on an input. The page number in each valid entry then names the table for the next level. The page number from the third entry is joined to the page offset to give a 45-bit physical address.

The block has a single-outstanding memory read port that returns 64-bit entries. Each walk issues exactly one read per level and waits for its data before it moves on. An entry whose valid bit is clear ends the walk early with a fault. Only one walk runs at a time. New requests are held off until the response cycle has passed.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_rd_valid` are 0.
- R2: The virtual address fields are as follows: `req_va[42:33]` is the first-level index, `req_va[32:23]` is the second, `req_va[22:13]` is the third, and `req_va[12:0]` is the page offset. The first read goes to `{ptbr_ppn, 13'b0} + idx1*8`, which is `{ptbr_ppn, idx1, 3'b000}`.
- R3: An entry carries its page number in bits [63:32]. The second read goes to `{ppn1, idx2, 3'b000}` and the third to `{ppn2, idx3, 3'b000}`, where ppnN is the page number in the entry returned for level N.
- R4: When all three entries are valid, the walk ends with `rsp_fault` = 0 and `rsp_pa` = `{ppn3, req_va[12:0]}`.
- R5: Bit 0 of an entry is its valid bit. If that bit is 0 at any level, the walk ends with `rsp_fault` = 1 and no further read is issued for that walk.
- R6: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the read request stays up and `mem_rd_addr` does not change. A level's read leaves the block exactly once, and the next read is not raised until that level's `mem_rsp_valid` arrives.
- R7: Once a request is accepted, `req_ready` stays 0 until the response cycle is over. A request presented during a walk is not taken and starts no reads.
- R8: Virtual address bits above bit 42 have no effect on the reads or on the result.
- R9: `rsp_valid` is a single-cycle pulse. In the following cycle the block is idle again, with `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr_ppn | input | 32 | Page number of the first-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | VA_W (64) | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Walk met an invalid entry |
| rsp_pa | output | 45 | Physical address (valid when no fault) |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 45 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |

## Verification
The bench sweeps every combination of zero, one, a mid value and all-ones in each of the three index fields. A design that swapped or misplaced index fields, or used the wrong entry bits as the next base, would send reads to wrong addresses and return a wrong physical address. Faults are injected at each level in turn: a walker that kept reading after an invalid entry would show extra reads, and one that ignored the valid bit would report no fault. Read stalls and varied memory latency catch an address that moves while waiting, or a duplicated read. Requests held high during a walk, and virtual addresses with upper bits set, catch a walker that restarts early or decodes the unused bits.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int OFF_W   = 13;
  localparam int IDX_W   = 10;
  localparam int LEVELS  = 3;
  localparam int PPN_W   = 32;
  localparam int PTE_W   = 64;
  localparam int ENT_SH  = 3;
  localparam int PA_W    = PPN_W + OFF_W;
  localparam int VAU_W   = OFF_W + LEVELS * IDX_W;
  localparam int LVL_W   = $clog2(LEVELS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1, ST_L2, ST_L3, ST_DONE
  } walk_state_e;

  // Byte address of one entry: table base plus index scaled by entry size
  function automatic logic [PA_W-1:0] entry_addr(input logic [PPN_W-1:0] base,
                                                 input logic [IDX_W-1:0] idx);
    logic [PA_W-1:0] tbl;
    logic [PA_W-1:0] ofs;
    tbl = {base, {OFF_W{1'b0}}};
    ofs = PA_W'({idx, {ENT_SH{1'b0}}});
    return tbl + ofs;
  endfunction

  // Index field for level lvl (0 = first level, highest field)
  function automatic logic [IDX_W-1:0] level_index(input logic [VAU_W-1:0] va,
                                                   input int lvl);
    return va[OFF_W + (LEVELS - 1 - lvl) * IDX_W +: IDX_W];
  endfunction

  function automatic logic [PPN_W-1:0] pte_ppn(input logic [PTE_W-1:0] pte);
    return pte[PTE_W-1 -: PPN_W];
  endfunction

  function automatic logic pte_valid(input logic [PTE_W-1:0] pte);
    return pte[0];
  endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [VAU_W-1:0] va,
  input  logic [LVL_W-1:0] lvl,
  input  logic [PPN_W-1:0] base,
  output logic [PA_W-1:0]  addr
);
  logic [IDX_W-1:0] idx_arr [LEVELS];
  logic [IDX_W-1:0] idx_sel;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_arr[g] = level_index(va, g);
  end

  always_comb begin
    idx_sel = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (int'(lvl) == k) idx_sel = idx_arr[k];
    end
  end

  assign addr = entry_addr(base, idx_sel);
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  output logic             ok,
  output logic [PPN_W-1:0] ppn
);
  logic unused_pte_bits;
  assign unused_pte_bits = ^pte[PTE_W-PPN_W-1:1];
  assign ok  = pte_valid(pte);
  assign ppn = pte_ppn(pte);
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VAU_W-1:0] req_va,
  input  logic [PPN_W-1:0] ptbr_ppn,
  output logic             req_ready,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  input  logic             mem_rsp_valid,
  input  logic             pte_ok,
  input  logic [PPN_W-1:0] pte_ppn_in,
  output logic [LVL_W-1:0] walk_lvl,
  output logic [PPN_W-1:0] cur_base,
  output logic [VAU_W-1:0] cur_va,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_pa
);
  walk_state_e      state_q;
  logic             issued_q;
  logic [PPN_W-1:0] base_q;
  logic [VAU_W-1:0] va_q;
  logic [PA_W-1:0]  pa_q;
  logic             fault_q;

  logic in_walk;
  logic last_lvl;
  logic ev_accept;
  logic ev_issue;
  logic ev_consume;

  assign in_walk    = (state_q == ST_L1) || (state_q == ST_L2) || (state_q == ST_L3);
  assign last_lvl   = (state_q == ST_L3);
  assign req_ready  = (state_q == ST_IDLE);
  assign ev_accept  = req_ready && req_valid;
  assign mem_rd_valid = in_walk && !issued_q;
  assign ev_issue   = mem_rd_valid && mem_rd_ready;
  assign ev_consume = in_walk && issued_q && mem_rsp_valid;

  always_comb begin
    unique case (state_q)
      ST_L2:   walk_lvl = LVL_W'(1);
      ST_L3:   walk_lvl = LVL_W'(2);
      default: walk_lvl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      base_q   <= '0;
      va_q     <= '0;
      pa_q     <= '0;
      fault_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ev_accept) begin
            state_q  <= ST_L1;
            base_q   <= ptbr_ppn;
            va_q     <= req_va;
            issued_q <= 1'b0;
          end
        end
        ST_L1, ST_L2, ST_L3: begin
          if (ev_issue) issued_q <= 1'b1;
          if (ev_consume) begin
            issued_q <= 1'b0;
            if (!pte_ok) begin
              fault_q <= 1'b1;
              pa_q    <= '0;
              state_q <= ST_DONE;
            end else if (last_lvl) begin
              fault_q <= 1'b0;
              pa_q    <= {pte_ppn_in, va_q[OFF_W-1:0]};
              state_q <= ST_DONE;
            end else begin
              base_q  <= pte_ppn_in;
              state_q <= (state_q == ST_L1) ? ST_L2 : ST_L3;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cur_base  = base_q;
  assign cur_va    = va_q;
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_fault = fault_q;
  assign rsp_pa    = pa_q;

  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> mem_rd_valid);
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);
  assert_fault_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_consume && !pte_ok) |=> (rsp_valid && rsp_fault && !mem_rd_valid));
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  assert_one_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue |=> !mem_rd_valid);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PPN_W-1:0]   ptbr_ppn,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [PA_W-1:0]    rsp_pa,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [PA_W-1:0]    mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_data
);
  localparam int HI_W = VA_W - VAU_W;

  logic [VAU_W-1:0] va_used;
  logic             pte_ok;
  logic [PPN_W-1:0] pte_ppn_w;
  logic [LVL_W-1:0] walk_lvl;
  logic [PPN_W-1:0] cur_base;
  logic [VAU_W-1:0] cur_va;

  assign va_used = req_va[VAU_W-1:0];

  if (HI_W > 0) begin : g_hi
    logic unused_va_hi;
    assign unused_va_hi = ^req_va[VA_W-1:VAU_W];
  end

  ptw_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_va       (va_used),
    .ptbr_ppn     (ptbr_ppn),
    .req_ready    (req_ready),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .pte_ok       (pte_ok),
    .pte_ppn_in   (pte_ppn_w),
    .walk_lvl     (walk_lvl),
    .cur_base     (cur_base),
    .cur_va       (cur_va),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_pa       (rsp_pa)
  );

  ptw_addr_gen u_addr (
    .va  (cur_va),
    .lvl (walk_lvl),
    .base(cur_base),
    .addr(mem_rd_addr)
  );

  ptw_pte_check u_pte (
    .pte(mem_rsp_data),
    .ok (pte_ok),
    .ppn(pte_ppn_w)
  );

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
  assert_no_rsp_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && (mem_rd_valid || req_ready)));
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ptbr_ppn = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [44:0] rsp_pa;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [44:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  int          stall_cfg = 0;
  int          lat_cfg = 0;
  logic [44:0] fault_addr = '1;
  int          rd_total = 0;
  logic [44:0] log_first [16];
  logic [44:0] log_addr  [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker #(.VA_W(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .ptbr_ppn(ptbr_ppn),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] ppn_of(input logic [44:0] a);
    return a[34:3] ^ 32'hA5C3_0F17 ^ {a[44:35], 22'h0};
  endfunction

  function automatic logic [63:0] pte_of(input logic [44:0] a);
    return {ppn_of(a), 31'h0, (a != fault_addr)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin : mem_model
    logic [44:0] a0;
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        a0 = mem_rd_addr;
        repeat (stall_cfg) @(negedge clk);
        log_first[rd_total % 16] = a0;
        log_addr[rd_total % 16]  = mem_rd_addr;
        rd_total = rd_total + 1;
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        repeat (lat_cfg) @(negedge clk);
        mem_rsp_data  = pte_of(log_addr[(rd_total - 1) % 16]);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic run_walk(input logic [63:0] va, input bit hold_busy);
    logic [9:0]  i1, i2, i3;
    logic [44:0] a [3];
    logic [31:0] p [3];
    int          nexp;
    bit          flt;
    int          start;
    int          waitc;
    i1 = va[42:33]; i2 = va[32:23]; i3 = va[22:13];
    a[0] = {ptbr_ppn, i1, 3'b000}; p[0] = ppn_of(a[0]);
    a[1] = {p[0], i2, 3'b000};     p[1] = ppn_of(a[1]);
    a[2] = {p[1], i3, 3'b000};     p[2] = ppn_of(a[2]);
    nexp = 3; flt = 0;
    for (int k = 0; k < 3; k++) begin
      if (!flt && a[k] == fault_addr) begin flt = 1; nexp = k + 1; end
    end
    start = rd_total;
    @(negedge clk);
    check("R7 ready before request", {63'h0, req_ready}, 64'h1);
    req_valid = 1'b1; req_va = va;
    @(negedge clk);
    if (hold_busy) req_va = ~va;
    else req_valid = 1'b0;
    check("R7 busy after accept", {63'h0, req_ready}, 64'h0);
    waitc = 0;
    while (!rsp_valid && waitc < 400) begin @(negedge clk); waitc++; end
    req_valid = 1'b0;
    check("R9 response seen", {63'h0, rsp_valid}, 64'h1);
    check("R5 fault flag", {63'h0, rsp_fault}, {63'h0, flt});
    if (!flt) check("R4 physical address", {19'h0, rsp_pa}, {19'h0, p[2], va[12:0]});
    check("R5 read count", 64'(rd_total - start), 64'(nexp));
    for (int k = 0; k < nexp && k < 3; k++) begin
      if (k == 0) check("R2 level1 entry address", {19'h0, log_addr[(start + k) % 16]}, {19'h0, a[k]});
      else        check("R3 next level entry address", {19'h0, log_addr[(start + k) % 16]}, {19'h0, a[k]});
      if (stall_cfg > 0)
        check("R6 address held under stall", {19'h0, log_addr[(start + k) % 16]},
              {19'h0, log_first[(start + k) % 16]});
    end
    @(negedge clk);
    check("R9 pulse ends, idle", {62'h0, rsp_valid, req_ready}, 64'h1);
    if (hold_busy) begin
      repeat (3) @(negedge clk);
      check("R7 no reads from held request", 64'(rd_total - start), 64'(nexp));
      check("R7 no read pending", {63'h0, mem_rd_valid}, 64'h0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [9:0] cv [4];
    logic [63:0] va;
    logic [44:0] t1;
    cv[0] = 10'h000; cv[1] = 10'h001; cv[2] = 10'h155; cv[3] = 10'h3FF;
    repeat (3) @(negedge clk);
    check("R1 reset req_ready", {63'h0, req_ready}, 64'h1);
    check("R1 reset rsp_valid", {63'h0, rsp_valid}, 64'h0);
    check("R1 reset mem_rd_valid", {63'h0, mem_rd_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {62'h0, mem_rd_valid, rsp_valid}, 64'h0);

    // index corner sweep
    for (int g = 0; g < 64; g++) begin
      ptbr_ppn  = 32'h0001_2000 + 32'(g * 32'h0101_0013);
      lat_cfg   = g % 3;
      stall_cfg = (g % 4 == 3) ? 2 : 0;
      va = {21'h0, cv[g / 16], cv[(g / 4) % 4], cv[g % 4], 13'(g * 97 + 5)};
      run_walk(va, 1'b0);
    end

    // faults at each level
    ptbr_ppn = 32'h00AB_CD00;
    stall_cfg = 1; lat_cfg = 1;
    va = {21'h0, 10'h123, 10'h2A5, 10'h07E, 13'h1ABC};
    fault_addr = {ptbr_ppn, va[42:33], 3'b000};
    run_walk(va, 1'b0);   // R5 level 1
    t1 = {ppn_of({ptbr_ppn, va[42:33], 3'b000}), va[32:23], 3'b000};
    fault_addr = t1;
    run_walk(va, 1'b0);   // R5 level 2
    fault_addr = {ppn_of(t1), va[22:13], 3'b000};
    run_walk(va, 1'b0);   // R5 level 3
    fault_addr = '1;

    // R8 upper bits ignored
    stall_cfg = 0; lat_cfg = 0;
    va = {21'h1F_FFFF, 10'h0F0, 10'h30F, 10'h211, 13'h0777};
    run_walk(va, 1'b0);
    va = {21'h0A_5A5A, 10'h0F0, 10'h30F, 10'h211, 13'h0777};
    run_walk(va, 1'b0);

    // R7 request held high during a walk
    lat_cfg = 2;
    va = {21'h0, 10'h3C3, 10'h00F, 10'h1E1, 13'h1FFF};
    run_walk(va, 1'b1);
    stall_cfg = 3;
    va = {21'h0, 10'h001, 10'h3FE, 10'h2AA, 13'h0000};
    run_walk(va, 1'b1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule